// File: doc/BRIEF.md
# Serial Channel Number Loader

This block receives a channel number over a two-line synchronous port made of a clock line and a data line. Both lines are asynchronous to the system clock. The block samples them with the system clock and resynchronises them before any decision is made. A load opens when the data line falls while the clock line is high. Eight bits then follow, least significant bit first, and each bit is captured on a rising edge of the line clock. The load closes when both lines are held high for a minimum time.

Every phase of a load has a minimum duration, measured in system clock cycles. These phases are:
- the opening hold;
- each low phase and each high phase of the line clock;
- the closing both-high window;
- the quiet gap since the previous load.

The block has no maximum durations. It accepts the received number only if every minimum was met, no extra clock pulse arrived and the value is within the allowed range. Otherwise it reports the fallback channel 0 and raises an error flag. The result appears with a single-cycle valid pulse and is held until the next load completes.

Top module: `chsel_serial_rx`

## Requirements
- R1: After reset, `chan_o` is 0, `chan_valid_o` is 0 and `chan_err_o` is 0. Both line inputs pass through a two-flop synchroniser, and the synchroniser resets to the idle-high level.
- R2: While idle, a load opens only when the data line falls while the clock line is high. Clock pulses seen before such an opening produce no result.
- R3: The eight bits are taken on rising edges of the line clock, least significant bit first. With correct timing and a value of at most `MAX_CHAN`, the received value appears on `chan_o` with `chan_err_o` at 0.
- R4: If fewer than `T_START` cycles pass between the opening data fall and the first clock fall, the result is channel 0 with `chan_err_o` at 1.
- R5: If any low phase of the line clock lasts fewer than `T_LOW` cycles, the result is channel 0 with `chan_err_o` at 1.
- R6: If any high phase of the line clock between bits lasts fewer than `T_HIGH` cycles, the result is channel 0 with `chan_err_o` at 1.
- R7: After the eighth rising edge, the result is produced only once both lines have been high together for `T_LATCH` consecutive cycles. A shorter both-high run produces nothing.
- R8: A received value above `MAX_CHAN` (100) gives channel 0 with `chan_err_o` at 1. A value of exactly 100 is accepted.
- R9: A load that opens fewer than `T_GAP` cycles after the previous result ends with channel 0 and `chan_err_o` at 1.
- R10: `chan_valid_o` is high for exactly one cycle per completed load. `chan_o` and `chan_err_o` change only in that cycle.
- R11: If the data line rises again while the clock line is still high during the opening hold, the load is dropped silently and no result is produced.
- R12: A clock fall after the eighth bit and before the closing window ends gives channel 0 with `chan_err_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the lines |
| rst_n | input | 1 | Synchronous active-low reset |
| line_clk_i | input | 1 | Serial clock line, asynchronous |
| line_dat_i | input | 1 | Serial data line, asynchronous |
| chan_o | output | 7 | Last channel result |
| chan_valid_o | output | 1 | One-cycle pulse when a result is produced |
| chan_err_o | output | 1 | Set when the last result was the fallback |

## Verification
A wrong phase state shows up at the ports in the cycle that the closing window would complete. That fault appears as one of three things:
- a missing valid pulse;
- an extra valid pulse;
- a result carrying the wrong value or the wrong error flag.

A corrupted shift position or bit count shows as a wrong value in the pulse that ends that same load. An off-by-one in a minimum-duration counter is only visible when a phase sits exactly at its limit. For that reason, the loads are driven with every phase both at its minimum and one cycle below it.

// File: rtl/chsel_pkg.sv
// Shared definitions for the serial channel loader.
// Assumes: nothing beyond IEEE 1800-2017.
package chsel_pkg;

    // Phases of one load on the two-line port.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // waiting for an opening condition
        ST_START = 3'd1,  // data low, clock high, before the first clock fall
        ST_LOW   = 3'd2,  // line clock low, bit being set up
        ST_HIGH  = 3'd3,  // line clock high between bits
        ST_WAIT  = 3'd4   // all bits in, waiting for the closing window
    } load_state_t;

endpackage

// File: rtl/chsel_sync.sv
// Two-flop synchroniser with edge detection for a group of asynchronous lines.
// Assumes: each line is held for at least two system clock cycles to be seen;
// RST_VAL gives the idle level of each line so no edge appears out of reset.
module chsel_sync #(
    parameter int unsigned   W       = 2,
    parameter logic [W-1:0]  RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    for (genvar g = 0; g < W; g++) begin : g_line
        logic meta_q;
        logic sync_q;
        logic prev_q;

        // Resynchronise one line and keep its previous level for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                sync_q <= RST_VAL[g];
                prev_q <= RST_VAL[g];
            end else begin
                meta_q <= raw_i[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign lvl_o[g]  = sync_q;
        assign rise_o[g] = sync_q & ~prev_q;
        assign fall_o[g] = ~sync_q & prev_q;
    end

endmodule

// File: rtl/chsel_sat_counter.sv
// Saturating up-counter with a synchronous clear.
// Assumes: W is wide enough to hold MAX; clear has priority over increment.
module chsel_sat_counter #(
    parameter int unsigned W   = 8,
    parameter int unsigned MAX = 255,
    parameter int unsigned RST = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] CNT_MAX = W'(MAX);
    localparam logic [W-1:0] CNT_RST = W'(RST);

    // Count up to MAX and stay there until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= CNT_RST;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (inc_i && (cnt_o != CNT_MAX)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/chsel_shifter.sv
// LSB-first bit collector for one load.
// Assumes: the caller clears it at the start of a load and shifts once per
// rising edge of the line clock; last_o flags that the next shift fills it.
module chsel_shifter #(
    parameter int unsigned BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            shift_i,
    input  logic            bit_i,
    output logic [BITS-1:0] data_o,
    output logic            last_o
);

    localparam int unsigned CW = $clog2(BITS + 1);

    logic [CW-1:0] count_q;

    // Shift new bits in from the top so the first bit ends at position 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            count_q <= '0;
        end else if (clr_i) begin
            data_o  <= '0;
            count_q <= '0;
        end else if (shift_i) begin
            data_o  <= {bit_i, data_o[BITS-1:1]};
            count_q <= count_q + 1'b1;
        end
    end

    assign last_o = (count_q == CW'(BITS - 1));

endmodule

// File: rtl/chsel_ctrl.sv
// Load sequencer: tracks the phases of one load and checks the minimum
// duration of each phase.
// Assumes: all line inputs are already synchronised; ph_cnt_i counts cycles
// since the last ph_clr_o; run_cnt_i counts the previous consecutive
// both-high cycles; gap_cnt_i counts cycles since the last fire_o.
module chsel_ctrl
    import chsel_pkg::*;
#(
    parameter int unsigned T_START = 6,
    parameter int unsigned T_LOW   = 3,
    parameter int unsigned T_HIGH  = 4,
    parameter int unsigned T_LATCH = 3,
    parameter int unsigned T_GAP   = 40,
    parameter int unsigned PH_W    = 3,
    parameter int unsigned RUN_W   = 2,
    parameter int unsigned GAP_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ck_lvl_i,
    input  logic             dt_lvl_i,
    input  logic             ck_rise_i,
    input  logic             ck_fall_i,
    input  logic             dt_rise_i,
    input  logic             dt_fall_i,
    input  logic [PH_W-1:0]  ph_cnt_i,
    input  logic [RUN_W-1:0] run_cnt_i,
    input  logic [GAP_W-1:0] gap_cnt_i,
    input  logic             last_bit_i,
    output logic             ph_clr_o,
    output logic             shift_o,
    output logic             frame_clr_o,
    output logic             fire_o,
    output logic             load_err_o
);

    load_state_t state_q, state_d;
    logic        err_q, err_d;
    logic        start_short, low_short, high_short, gap_short, latch_done;

    // A phase is too short when it ended before reaching its minimum length.
    assign start_short = (int'(ph_cnt_i) + 1) < int'(T_START);
    assign low_short   = (int'(ph_cnt_i) + 1) < int'(T_LOW);
    assign high_short  = (int'(ph_cnt_i) + 1) < int'(T_HIGH);
    assign gap_short   = int'(gap_cnt_i) < int'(T_GAP);
    assign latch_done  = ck_lvl_i && dt_lvl_i && ((int'(run_cnt_i) + 1) >= int'(T_LATCH));

    // Next phase, timing error collection and strobes for the datapath.
    always_comb begin
        state_d     = state_q;
        err_d       = err_q;
        ph_clr_o    = 1'b0;
        shift_o     = 1'b0;
        frame_clr_o = 1'b0;
        fire_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ck_lvl_i && dt_fall_i) begin
                    state_d     = ST_START;
                    err_d       = gap_short;
                    ph_clr_o    = 1'b1;
                    frame_clr_o = 1'b1;
                end
            end
            ST_START: begin
                if (ck_fall_i) begin
                    state_d  = ST_LOW;
                    err_d    = err_q | start_short;
                    ph_clr_o = 1'b1;
                end else if (dt_rise_i && ck_lvl_i) begin
                    state_d = ST_IDLE;
                end
            end
            ST_LOW: begin
                if (ck_rise_i) begin
                    state_d  = last_bit_i ? ST_WAIT : ST_HIGH;
                    err_d    = err_q | low_short;
                    shift_o  = 1'b1;
                    ph_clr_o = 1'b1;
                end
            end
            ST_HIGH: begin
                if (ck_fall_i) begin
                    state_d  = ST_LOW;
                    err_d    = err_q | high_short;
                    ph_clr_o = 1'b1;
                end
            end
            ST_WAIT: begin
                if (ck_fall_i) begin
                    err_d = 1'b1;
                end else if (latch_done) begin
                    state_d = ST_IDLE;
                    fire_o  = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Phase and error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    assign load_err_o = err_q;

endmodule

// File: rtl/chsel_serial_rx.sv
// Serial channel loader top: synchronises the two lines, sequences a load,
// collects the bits and issues the channel result with a one-cycle pulse.
// Assumes: the T_* minimums are in system clock cycles, T_LATCH >= 2, and the
// lines idle high. Defaults match a 50 MHz system clock.
module chsel_serial_rx #(
    parameter int unsigned FRAME_BITS = 8,
    parameter int unsigned MAX_CHAN   = 100,
    parameter int unsigned FALLBACK   = 0,
    parameter int unsigned T_START    = 1250,
    parameter int unsigned T_LOW      = 250,
    parameter int unsigned T_HIGH     = 400,
    parameter int unsigned T_LATCH    = 250,
    parameter int unsigned T_GAP      = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_clk_i,
    input  logic       line_dat_i,
    output logic [6:0] chan_o,
    output logic       chan_valid_o,
    output logic       chan_err_o
);

    localparam int unsigned CHAN_W = $clog2(MAX_CHAN + 1);
    localparam int unsigned PH_MAX = (T_START > T_LOW)
                                   ? ((T_START > T_HIGH) ? T_START : T_HIGH)
                                   : ((T_LOW > T_HIGH) ? T_LOW : T_HIGH);
    localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
    localparam int unsigned RUN_W  = $clog2(T_LATCH + 1);
    localparam int unsigned GAP_W  = $clog2(T_GAP + 1);

    logic [1:0]            lvl, rise, fall;
    logic                  ck_lvl, dt_lvl, both_high;
    logic [PH_W-1:0]       ph_cnt;
    logic [RUN_W-1:0]      run_cnt;
    logic [GAP_W-1:0]      gap_cnt;
    logic [FRAME_BITS-1:0] frame;
    logic                  last_bit, ph_clr, shift, frame_clr, fire, load_err;
    logic                  out_of_range, take_fallback;

    chsel_sync #(
        .W       (2),
        .RST_VAL (2'b11)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({line_dat_i, line_clk_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign ck_lvl    = lvl[0];
    assign dt_lvl    = lvl[1];
    assign both_high = ck_lvl & dt_lvl;

    chsel_sat_counter #(
        .W   (PH_W),
        .MAX (PH_MAX),
        .RST (0)
    ) i_phase_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ph_clr),
        .inc_i (1'b1),
        .cnt_o (ph_cnt)
    );

    chsel_sat_counter #(
        .W   (RUN_W),
        .MAX (T_LATCH),
        .RST (0)
    ) i_run_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (~both_high),
        .inc_i (both_high),
        .cnt_o (run_cnt)
    );

    chsel_sat_counter #(
        .W   (GAP_W),
        .MAX (T_GAP),
        .RST (T_GAP)
    ) i_gap_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (fire),
        .inc_i (1'b1),
        .cnt_o (gap_cnt)
    );

    chsel_shifter #(
        .BITS (FRAME_BITS)
    ) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (frame_clr),
        .shift_i (shift),
        .bit_i   (dt_lvl),
        .data_o  (frame),
        .last_o  (last_bit)
    );

    chsel_ctrl #(
        .T_START (T_START),
        .T_LOW   (T_LOW),
        .T_HIGH  (T_HIGH),
        .T_LATCH (T_LATCH),
        .T_GAP   (T_GAP),
        .PH_W    (PH_W),
        .RUN_W   (RUN_W),
        .GAP_W   (GAP_W)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ck_lvl_i    (ck_lvl),
        .dt_lvl_i    (dt_lvl),
        .ck_rise_i   (rise[0]),
        .ck_fall_i   (fall[0]),
        .dt_rise_i   (rise[1]),
        .dt_fall_i   (fall[1]),
        .ph_cnt_i    (ph_cnt),
        .run_cnt_i   (run_cnt),
        .gap_cnt_i   (gap_cnt),
        .last_bit_i  (last_bit),
        .ph_clr_o    (ph_clr),
        .shift_o     (shift),
        .frame_clr_o (frame_clr),
        .fire_o      (fire),
        .load_err_o  (load_err)
    );

    assign out_of_range  = int'(frame) > int'(MAX_CHAN);
    assign take_fallback = load_err | out_of_range;

    // Register the result and its pulse when a load closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_o       <= '0;
            chan_valid_o <= 1'b0;
            chan_err_o   <= 1'b0;
        end else begin
            chan_valid_o <= fire;
            if (fire) begin
                chan_o     <= take_fallback ? 7'(FALLBACK) : 7'(frame[CHAN_W-1:0]);
                chan_err_o <= take_fallback;
            end
        end
    end

endmodule

// File: rtl/chsel_checks.sv
// Property checker for the serial channel loader, bound to its top.
// Assumes: lines_high is the synchronised both-lines-high level.
module chsel_checks #(
    parameter int unsigned MAX_CHAN = 100,
    parameter int unsigned FALLBACK = 0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       valid,
    input logic [6:0] chan,
    input logic       err,
    input logic       lines_high
);

    // R10: a result pulse lasts one cycle.
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R10: the result holds between pulses.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(chan) && $stable(err)));

    // R8: a flagged result carries the fallback channel.
    a_r8_fallback_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && err) |-> (chan == 7'(FALLBACK)));

    // R8: no result exceeds the allowed range.
    a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (int'(chan) <= int'(MAX_CHAN)));

    // R7: a result only follows a cycle with both lines high.
    a_r7_latch_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(lines_high));

endmodule

bind chsel_serial_rx chsel_checks #(
    .MAX_CHAN (MAX_CHAN),
    .FALLBACK (FALLBACK)
) i_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (chan_valid_o),
    .chan       (chan_o),
    .err        (chan_err_o),
    .lines_high (both_high)
);

// File: tb/test_chsel_serial_rx.sv
`timescale 1ns/1ps
module test_chsel_serial_rx;

    localparam int TS = 6, TL = 3, TH = 4, TLAT = 3, TG = 40, MAXC = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ck = 1'b1;
    logic       dt = 1'b1;
    logic [6:0] chan;
    logic       valid, err;
    int         n_cmp = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    chsel_serial_rx #(
        .FRAME_BITS (8), .MAX_CHAN (MAXC), .FALLBACK (0),
        .T_START (TS), .T_LOW (TL), .T_HIGH (TH), .T_LATCH (TLAT), .T_GAP (TG)
    ) i_chsel_serial_rx (
        .clk (clk), .rst_n (rst_n), .line_clk_i (ck), .line_dat_i (dt),
        .chan_o (chan), .chan_valid_o (valid), .chan_err_o (err)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Opening, eight bits LSB first, final rise; data stays at bit 7 one cycle.
    task automatic drive_bits(input logic [7:0] v, input int ts, input int tl, input int th);
        dt = 1'b0;
        cyc(ts);
        for (int i = 0; i < 8; i++) begin
            ck = 1'b0;
            dt = v[i];
            cyc(tl);
            ck = 1'b1;
            if (i < 7) cyc(th);
        end
        cyc(1);
    endtask

    // Watch the outputs for a window and report pulses and the last result.
    task automatic collect(output int np, output int c, output int e);
        np = 0; c = -1; e = -1;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (valid) begin
                np++;
                c = int'(chan);
                e = int'(err);
            end
        end
    endtask

    task automatic load_and_check(input string req, input logic [7:0] v,
                                  input int ts, input int tl, input int th,
                                  input int exp_c, input int exp_e);
        int np, c, e;
        drive_bits(v, ts, tl, th);
        dt = 1'b1;
        collect(np, c, e);
        check({req, " pulses"}, np, 1);
        check({req, " chan"}, c, exp_c);
        check({req, " err"}, e, exp_e);
        cyc(TG);
    endtask

    initial begin
        int np, c, e;
        cyc(4);
        // R1: reset state.
        check("R1 chan", int'(chan), 0);
        check("R1 valid", int'(valid), 0);
        check("R1 err", int'(err), 0);
        rst_n = 1'b1;
        cyc(5);
        check("R1 idle after reset", int'(valid), 0);

        // R2: clock pulses without an opening produce nothing.
        ck = 1'b0; dt = 1'b0; cyc(3);
        for (int i = 0; i < 9; i++) begin
            ck = 1'b1; cyc(TH); ck = 1'b0; dt = ~dt; cyc(TL);
        end
        ck = 1'b1; cyc(2); dt = 1'b1;
        collect(np, c, e);
        check("R2 no result", np, 0);
        cyc(TG);

        // R3 / R8 / R10: every value at exact minimum timing.
        for (int v = 0; v < 256; v++) begin
            load_and_check(v > MAXC ? "R8 sweep" : "R3 sweep", 8'(v), TS, TL, TH,
                           v > MAXC ? 0 : v, v > MAXC ? 1 : 0);
        end
        load_and_check("R8 boundary 100", 8'd100, TS, TL, TH, 100, 0);
        load_and_check("R8 boundary 101", 8'd101, TS, TL, TH, 0, 1);

        // R4 / R5 / R6: one cycle short of each minimum.
        load_and_check("R4 short start", 8'd37, TS - 1, TL, TH, 0, 1);
        load_and_check("R4 exact start", 8'd37, TS, TL, TH, 37, 0);
        load_and_check("R5 short low", 8'd58, TS, TL - 1, TH, 0, 1);
        load_and_check("R6 short high", 8'd58, TS, TL, TH - 1, 0, 1);
        load_and_check("R6 long phases", 8'd58, TS + 9, TL + 7, TH + 11, 58, 0);

        // R7: a closing run one cycle short produces nothing; a full one does.
        drive_bits(8'd42, TS, TL, TH);
        dt = 1'b1; cyc(TLAT - 1); dt = 1'b0;
        collect(np, c, e);
        check("R7 short window", np, 0);
        dt = 1'b1;
        collect(np, c, e);
        check("R7 full window pulses", np, 1);
        check("R7 full window chan", c, 42);
        check("R7 full window err", e, 0);
        cyc(TG);

        // R9: an opening too soon after a result is flagged.
        drive_bits(8'd12, TS, TL, TH);
        dt = 1'b1;
        collect(np, c, e);
        load_and_check("R9 gap too short", 8'd9, TS, TL, TH, 0, 1);
        load_and_check("R9 gap respected", 8'd9, TS, TL, TH, 9, 0);

        // R11: data rises during the opening hold; the load is dropped.
        dt = 1'b0; cyc(2); dt = 1'b1; cyc(4);
        for (int i = 0; i < 8; i++) begin
            ck = 1'b0; cyc(TL); ck = 1'b1; cyc(TH);
        end
        collect(np, c, e);
        check("R11 dropped load", np, 0);
        check("R11 chan held", int'(chan), 9);
        load_and_check("R11 next load", 8'd77, TS, TL, TH, 77, 0);

        // R12: an extra clock pulse after the eighth bit.
        drive_bits(8'd20, TS, TL, TH);
        ck = 1'b0; cyc(TL); ck = 1'b1; cyc(1); dt = 1'b1;
        collect(np, c, e);
        check("R12 pulses", np, 1);
        check("R12 chan", c, 0);
        check("R12 err", e, 1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule